// File: doc/BRIEF.md
# Powered-Device Power-Path Sequencer

This block is the digital control state machine for the hot-swap pass switch of a powered device on an Ethernet power feed. Comparators outside the block turn the line and switch voltages into flags: the line is above the rising turn-on threshold, the line is above the lower turn-off threshold, the switch drain-source voltage is below the power-good low level, and it is below the power-good upper level. Two more flags report that the switch gate is high, which means the switch has left current limiting, and that the die temperature has crossed the shutdown or release point.

From these flags the block produces four things. It enables the pass switch. It chooses between the small inrush current limit and the larger operational limit. It enables the internal regulators. It enables the downstream DC-DC converter and holds soft-start discharged while that converter is off.

A changed line level is acted on only after it has held for a programmable filter time. This keeps short sags on the cable from causing power cycles. After a thermal trip clears, the block restarts by itself in the inrush state.

Top module: `pd_power_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `sw_en`, `lim_oper`, `conv_en` and `reg_en` are 0 and `ss_dis` is 1.
- R2: The block turns on only after `line_on_ok` has been 1 at FILTER_CYC consecutive clock edges. `sw_en` and `reg_en` rise one edge after the last of those. A shorter run of `line_on_ok` is ignored and leaves all outputs unchanged.
- R3: Once on, the block stays on while `line_off_ok` is 1, even when `line_on_ok` is 0 (the hysteresis band). It turns off only after `line_off_ok` has been 0 at FILTER_CYC consecutive edges, and `sw_en` falls one edge after the last of those. A shorter dip is ignored.
- R4: Every time `sw_en` rises, `lim_oper` is 0, so the inrush current limit is always selected first.
- R5: In the inrush state, `lim_oper` becomes 1 at the edge after an edge where `vds_lo_ok` and `gate_hi` are both 1. Either flag alone keeps the inrush limit.
- R6: In the operational state, the operational limit stays selected while `vds_hi_ok` is 1. At the edge after an edge where `vds_hi_ok` is 0, the block returns to the inrush limit with `sw_en` still 1.
- R7: `conv_en` is 1 only when `lim_oper` is 1, and `ss_dis` is always the inverse of `conv_en`.
- R8: An edge with `ot_set` = 1 latches overtemperature, with priority over `ot_clr`. By the second edge after it, `sw_en`, `reg_en` and `conv_en` are 0. They stay 0 until an edge with `ot_clr` = 1 and `ot_set` = 0.
- R9: When overtemperature is released and the filtered line is still up, the block re-enters the inrush state one edge after the release is latched, with `sw_en` and `reg_en` at 1 and `conv_en` at 0.
- R10: A filtered line loss takes priority over every other state, including thermal shutdown. If the line is down when overtemperature is released, the block stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_on_ok | input | 1 | Line above rising turn-on threshold |
| line_off_ok | input | 1 | Line above falling turn-off threshold |
| vds_lo_ok | input | 1 | Switch drain-source voltage below power-good low level |
| vds_hi_ok | input | 1 | Switch drain-source voltage below power-good upper level |
| gate_hi | input | 1 | Switch gate high (not current limiting) |
| ot_set | input | 1 | Die temperature above shutdown point |
| ot_clr | input | 1 | Die temperature below release point |
| sw_en | output | 1 | Pass switch enable |
| lim_oper | output | 1 | 1 selects operational current limit, 0 selects inrush limit |
| reg_en | output | 1 | Internal regulator enable |
| conv_en | output | 1 | Downstream converter enable |
| ss_dis | output | 1 | Soft-start discharge hold |

## Verification
The line filter is driven with runs of `line_on_ok` one cycle short of the filter time and with runs exactly long enough, which shows whether the count boundary is exact. It is also driven with short and full dips of `line_off_ok` while `line_on_ok` is low, which separates hysteresis holding from turn-off. The limit handover is tried with the drain-source flag alone, the gate flag alone and both together, which shows that the two conditions are ANDed. The upper power-good flag is then dropped to show where the operational limit is held and where it is released. Thermal trips are released once with the line up, which must restart in inrush, and once after a line loss, which must stay off.

// File: rtl/pd_seq_pkg.sv
// Shared types for the power-path sequencer.
package pd_seq_pkg;
    // Power-path control states.
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_INRUSH = 2'd1,
        PS_OPER   = 2'd2,
        PS_THERM  = 2'd3
    } pd_state_e;
endpackage

// File: rtl/pd_uv_filter.sv
// Line-level filter with hysteresis.
// Flips its filtered "line up" output only after the relevant comparator
// flag has held at FILTER_CYC consecutive edges: the turn-on flag while down,
// and the inverted turn-off flag while up.
// Assumes FILTER_CYC >= 1.
module pd_uv_filter #(
    parameter int FILTER_CYC = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_on_ok,
    input  logic line_off_ok,
    output logic line_up
);
    localparam int CW = $clog2(FILTER_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILTER_CYC - 1);

    logic [CW-1:0] run_cnt;
    logic          flip_req;

    // Which condition would move the filtered state away from its present value.
    always_comb flip_req = line_up ? !line_off_ok : line_on_ok;

    // Count consecutive requesting edges and flip at the end of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_up <= 1'b0;
            run_cnt <= '0;
        end else if (!flip_req) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            line_up <= !line_up;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pd_thermal_latch.sv
// Overtemperature latch.
// Separate trip and release flags model the thermal hysteresis; the trip
// flag wins when both are present.
module pd_thermal_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ot_set,
    input  logic ot_clr,
    output logic hot
);
    // Hold the shutdown condition between trip and release.
    always_ff @(posedge clk) begin
        if (!rst_n)      hot <= 1'b0;
        else if (ot_set) hot <= 1'b1;
        else if (ot_clr) hot <= 1'b0;
    end
endmodule

// File: rtl/pd_path_fsm.sv
// Power-path state machine.
// Sequences off -> inrush -> operational, with thermal shutdown and
// undervoltage overrides. Outputs are decoded from the state register only.
// Assumes line_up and hot are already filtered and latched.
module pd_path_fsm
    import pd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_up,
    input  logic hot,
    input  logic vds_lo_ok,
    input  logic vds_hi_ok,
    input  logic gate_hi,
    output logic sw_en,
    output logic lim_oper,
    output logic reg_en,
    output logic conv_en,
    output logic ss_dis
);
    pd_state_e state_q, state_d;

    // Next state: line loss first, then thermal, then per-state sequencing.
    always_comb begin
        state_d = state_q;
        if (!line_up) begin
            state_d = PS_OFF;
        end else if (hot) begin
            state_d = PS_THERM;
        end else begin
            unique case (state_q)
                PS_OFF:    state_d = PS_INRUSH;
                PS_INRUSH: if (vds_lo_ok && gate_hi) state_d = PS_OPER;
                PS_OPER:   if (!vds_hi_ok) state_d = PS_INRUSH;
                PS_THERM:  state_d = PS_INRUSH;
                default:   state_d = PS_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        sw_en    = (state_q == PS_INRUSH) || (state_q == PS_OPER);
        reg_en   = sw_en;
        lim_oper = (state_q == PS_OPER);
        conv_en  = (state_q == PS_OPER);
        ss_dis   = (state_q != PS_OPER);
    end
endmodule

// File: rtl/pd_power_sequencer.sv
// Top of the powered-device power-path sequencer.
// Filters the line comparators, latches overtemperature and drives the
// switch, current-limit select, regulator and converter enables.
// All inputs are assumed synchronous to clk.
module pd_power_sequencer #(
    parameter int FILTER_CYC = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_on_ok,
    input  logic line_off_ok,
    input  logic vds_lo_ok,
    input  logic vds_hi_ok,
    input  logic gate_hi,
    input  logic ot_set,
    input  logic ot_clr,
    output logic sw_en,
    output logic lim_oper,
    output logic reg_en,
    output logic conv_en,
    output logic ss_dis
);
    logic line_up;
    logic hot;

    pd_uv_filter #(.FILTER_CYC(FILTER_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .line_on_ok(line_on_ok), .line_off_ok(line_off_ok),
        .line_up(line_up)
    );

    pd_thermal_latch u_therm (
        .clk(clk), .rst_n(rst_n),
        .ot_set(ot_set), .ot_clr(ot_clr),
        .hot(hot)
    );

    pd_path_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .line_up(line_up), .hot(hot),
        .vds_lo_ok(vds_lo_ok), .vds_hi_ok(vds_hi_ok), .gate_hi(gate_hi),
        .sw_en(sw_en), .lim_oper(lim_oper), .reg_en(reg_en),
        .conv_en(conv_en), .ss_dis(ss_dis)
    );
endmodule

// File: rtl/pd_power_sequencer_chk.sv
// Property checker for the power-path sequencer, bound to the top module.
module pd_power_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic vds_lo_ok,
    input logic vds_hi_ok,
    input logic gate_hi,
    input logic ot_set,
    input logic sw_en,
    input logic lim_oper,
    input logic reg_en,
    input logic conv_en
);
    AST_CONV_NEEDS_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> (lim_oper && sw_en)); // R7

    AST_INRUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> !lim_oper); // R4

    AST_OPER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lim_oper) |-> $past(vds_lo_ok && gate_hi)); // R5

    AST_OPER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lim_oper) && sw_en) |-> !$past(vds_hi_ok)); // R6

    AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ot_set |=> ##1 (!sw_en && !reg_en && !conv_en)); // R8
endmodule

bind pd_power_sequencer pd_power_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .vds_lo_ok(vds_lo_ok), .vds_hi_ok(vds_hi_ok), .gate_hi(gate_hi),
    .ot_set(ot_set),
    .sw_en(sw_en), .lim_oper(lim_oper), .reg_en(reg_en), .conv_en(conv_en)
);

// File: tb/tb_pd_power_sequencer.sv
`timescale 1ns/1ps
module tb_pd_power_sequencer;
    localparam int FC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_on_ok = 0, line_off_ok = 0, vds_lo_ok = 0, vds_hi_ok = 0;
    logic gate_hi = 0, ot_set = 0, ot_clr = 0;
    logic sw_en, lim_oper, reg_en, conv_en, ss_dis;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference: mode 0 off, 1 inrush, 2 operational, 3 thermal.
    int m_mode = 0;
    int m_run = 0;
    bit m_up = 0;
    bit m_hot = 0;

    pd_power_sequencer #(.FILTER_CYC(FC)) dut (
        .clk(clk), .rst_n(rst_n),
        .line_on_ok(line_on_ok), .line_off_ok(line_off_ok),
        .vds_lo_ok(vds_lo_ok), .vds_hi_ok(vds_hi_ok), .gate_hi(gate_hi),
        .ot_set(ot_set), .ot_clr(ot_clr),
        .sw_en(sw_en), .lim_oper(lim_oper), .reg_en(reg_en),
        .conv_en(conv_en), .ss_dis(ss_dis)
    );

    always #2.5 clk = ~clk;

    task automatic expect_bit(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, got, exp, $time);
        end
    endtask

    // Advance the reference by one edge using the inputs that edge sampled.
    task automatic model_edge();
        int nxt;
        bit want;
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_up = 0; m_hot = 0;
            return;
        end
        nxt = m_mode;
        if (!m_up) nxt = 0;
        else if (m_hot) nxt = 3;
        else if (m_mode == 0 || m_mode == 3) nxt = 1;
        else if (m_mode == 1 && vds_lo_ok && gate_hi) nxt = 2;
        else if (m_mode == 2 && !vds_hi_ok) nxt = 1;
        want = m_up ? !line_off_ok : line_on_ok;
        if (!want) m_run = 0;
        else begin
            m_run++;
            if (m_run == FC) begin m_up = !m_up; m_run = 0; end
        end
        if (ot_set) m_hot = 1;
        else if (ot_clr) m_hot = 0;
        m_mode = nxt;
    endtask

    // One clock: update the model, then compare every output.
    task automatic step();
        @(posedge clk);
        #1;
        cycles++;
        model_edge();
        expect_bit("R2", "sw_en", sw_en, m_mode == 1 || m_mode == 2);
        expect_bit("R8", "reg_en", reg_en, m_mode == 1 || m_mode == 2);
        expect_bit("R5", "lim_oper", lim_oper, m_mode == 2);
        expect_bit("R7", "conv_en", conv_en, m_mode == 2);
        expect_bit("R7", "ss_dis", ss_dis, m_mode != 2);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        steps(3);
        expect_bit("R1", "reset sw_en", sw_en, 0);
        expect_bit("R1", "reset ss_dis", ss_dis, 1);
        rst_n = 1;
        steps(2);

        // R2: a run one cycle short is ignored
        line_on_ok = 1; line_off_ok = 1;
        steps(FC - 1);
        line_on_ok = 0; line_off_ok = 0;
        steps(3);
        expect_bit("R2", "short run ignored", sw_en, 0);

        // R2/R4: full run turns on, in inrush
        line_on_ok = 1; line_off_ok = 1;
        steps(FC);
        expect_bit("R2", "not yet on at filter end", sw_en, 0);
        steps(1);
        expect_bit("R2", "on after filter", sw_en, 1);
        expect_bit("R4", "inrush first", lim_oper, 0);

        // R5: each flag alone keeps inrush; both together hand over
        vds_lo_ok = 1; vds_hi_ok = 1; gate_hi = 0;
        steps(3);
        expect_bit("R5", "vds alone", lim_oper, 0);
        vds_lo_ok = 0; gate_hi = 1;
        steps(3);
        expect_bit("R5", "gate alone", lim_oper, 0);
        vds_lo_ok = 1;
        steps(1);
        expect_bit("R5", "both flags", lim_oper, 1);
        expect_bit("R7", "conv on in oper", conv_en, 1);

        // R6: low level leaving does not release; upper level does
        vds_lo_ok = 0;
        steps(3);
        expect_bit("R6", "held on upper level", lim_oper, 1);
        vds_hi_ok = 0; gate_hi = 0;
        steps(1);
        expect_bit("R6", "released to inrush", lim_oper, 0);
        expect_bit("R6", "switch kept on", sw_en, 1);
        vds_lo_ok = 1; vds_hi_ok = 1; gate_hi = 1;
        steps(2);

        // R3: hysteresis band and short dip
        line_on_ok = 0;
        steps(FC + 5);
        expect_bit("R3", "band keeps on", sw_en, 1);
        line_off_ok = 0;
        steps(FC - 1);
        line_off_ok = 1;
        steps(3);
        expect_bit("R3", "short dip ignored", sw_en, 1);

        // R8/R9: thermal trip with clear at the same time, then release
        ot_set = 1; ot_clr = 1;
        steps(1);
        ot_set = 0; ot_clr = 0;
        steps(1);
        expect_bit("R8", "switch off on trip", sw_en, 0);
        expect_bit("R8", "regs off on trip", reg_en, 0);
        steps(5);
        expect_bit("R8", "held off", sw_en, 0);
        ot_clr = 1;
        steps(1);
        ot_clr = 0;
        steps(1);
        expect_bit("R9", "restart switch", sw_en, 1);
        expect_bit("R9", "restart conv off", conv_en, 0);
        expect_bit("R9", "restart inrush", lim_oper, 0);
        steps(2);
        expect_bit("R9", "oper again", lim_oper, 1);

        // R10: line loss during thermal, release with line down stays off
        ot_set = 1;
        steps(1);
        ot_set = 0;
        line_off_ok = 0;
        steps(FC + 2);
        ot_clr = 1;
        steps(1);
        ot_clr = 0;
        steps(4);
        expect_bit("R10", "stays off", sw_en, 0);

        // R3: full turn-off from operation
        line_on_ok = 1; line_off_ok = 1;
        steps(FC + 4);
        expect_bit("R2", "back on", sw_en, 1);
        line_on_ok = 0; line_off_ok = 0;
        steps(FC);
        expect_bit("R3", "still on at filter end", sw_en, 1);
        steps(1);
        expect_bit("R3", "off after filter", sw_en, 0);
        steps(3);

        finish_run();
    end
endmodule